// File: doc/BRIEF.md
# Conference Mixer with Coded Output Gain

Once per sample period this block builds one mixed linear sample for every channel. Each channel's result is its own sample plus as many as three other channels' samples, picked from a per-channel configuration word. The sum is then scaled by one of four fixed gain steps and clamped to the signed 16-bit range. All samples are 16-bit two's complement linear values.

A one-cycle `start` pulse begins a frame. At that edge the block captures every channel's sample and configuration word, so all results in the frame come from the same set of inputs, whatever order the channels are processed in. The block then produces one result per cycle, in channel index order, on a valid/channel/data output. `done` marks the last result of the frame.

Top module: `conf_mixer`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `done` and `out_data` are all zero until a frame is started.
- R2: A `start` sampled high while idle begins a frame. The result for channel k is valid on the outputs after the (k+2)-th rising edge, counting the edge that sampled `start` as the first. Results come in channel order 0 to NCH-1, one per cycle, and `out_ch` carries the channel index.
- R3: When the mode field is 00, the result is the channel's own sample with the gain applied.
- R4: Mode 01 adds source A, mode 10 adds sources A and B, and mode 11 adds sources A, B and C, always on top of the channel's own sample. A source that is named twice, or that names the channel itself, is added once for each time it is named.
- R5: The gain code behaves as follows: 00 leaves the sum unchanged, 01 doubles it (+6 dB), 10 shifts it arithmetically right by two (-12 dB), and 11 shifts it arithmetically right by one (-6 dB). Right shifts round toward minus infinity.
- R6: The sum is built wide and gain is applied before clamping. A value above 32767 comes out as 32767, and a value below -32768 comes out as -32768.
- R7: The configuration word for channel k sits at `cfg_in[16k+15:16k]`. Bits [15:14] hold the gain, [13:12] the mode, [11:8] source A, [7:4] source B and [3:0] source C. Channel k's sample sits at `samp_in[16k+15:16k]`. A source index of NCH or above contributes zero.
- R8: Changes on `samp_in` and `cfg_in` after the start edge do not affect the results of the frame already running.
- R9: `done` is high for exactly one cycle, together with the last channel's result. A `start` that arrives while a frame is running is ignored and does not begin another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame when sampled high while idle |
| samp_in | input | NCH*16 | Current linear samples, channel k in bits [16k+15:16k] |
| cfg_in | input | NCH*16 | Per-channel configuration words |
| out_valid | output | 1 | A result is present on `out_ch`/`out_data` |
| out_ch | output | log2(NCH) | Channel index of the current result |
| out_data | output | 16 | Mixed, gain-scaled, clamped sample |
| done | output | 1 | Marks the last result of a frame |

## Verification
The start edge captures the inputs. The result for channel k appears k+1 edges later, so channel 0 is due one edge after the start edge and channel NCH-1 arrives together with `done` NCH edges after it. The bench raises `start` on a falling edge, which makes the next rising edge the start edge. It then checks one result on each following falling edge against a model that works from the captured inputs, which places every sample half a period away from the edge that updated the output. In the disturbance test, the inputs change and a second `start` is raised on the very next falling edge. The bench then watches the idle cycles that follow to confirm that no second frame begins.

// File: rtl/conf_mix_pkg.sv
package conf_mix_pkg;

  localparam int CFG_W = 16;

  typedef enum logic [1:0] {
    GAIN_UNITY = 2'b00,
    GAIN_UP6   = 2'b01,
    GAIN_DN12  = 2'b10,
    GAIN_DN6   = 2'b11
  } gain_code_e;

  typedef struct packed {
    logic [1:0] gain;
    logic [1:0] mode;
    logic [3:0] src_a;
    logic [3:0] src_b;
    logic [3:0] src_c;
  } mix_cfg_t;

endpackage

// File: rtl/conf_mix_snap.sv
// Holds the frame's sample and configuration set; loaded on capture only.
module conf_mix_snap #(
  parameter int NCH = 8,
  parameter int SW  = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             capture,
  input  logic [NCH*SW-1:0]                samp_in,
  input  logic [NCH*conf_mix_pkg::CFG_W-1:0] cfg_in,
  output logic [NCH*SW-1:0]                samp_q,
  output logic [NCH*conf_mix_pkg::CFG_W-1:0] cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= '0;
      cfg_q  <= '0;
    end else if (capture) begin
      samp_q <= samp_in;
      cfg_q  <= cfg_in;
    end
  end

endmodule

// File: rtl/conf_mix_seq.sv
// Frame sequencer: walks the channel index once per accepted start.
module conf_mix_seq #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           capture,
  output logic           step_en,
  output logic [CHW-1:0] step_ch,
  output logic           step_last
);

  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  logic           busy;
  logic [CHW-1:0] cnt;

  assign capture   = start && !busy;
  assign step_en   = busy;
  assign step_ch   = cnt;
  assign step_last = busy && (cnt == LAST_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      if (cnt == LAST_CH) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/conf_mix_core.sv
// Sum, gain and clamp for one channel per cycle; registered result.
module conf_mix_core
  import conf_mix_pkg::*;
#(
  parameter int NCH = 8,
  parameter int SW  = 16,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ACCW = SW + 2,
  localparam int GW   = ACCW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step_en,
  input  logic [CHW-1:0]          step_ch,
  input  logic                    step_last,
  input  logic [NCH*SW-1:0]       snap_samp,
  input  logic [NCH*CFG_W-1:0]    snap_cfg,
  output logic                    out_valid,
  output logic [CHW-1:0]          out_ch,
  output logic [SW-1:0]           out_data,
  output logic                    done
);

  localparam logic signed [GW-1:0] SAT_HI = {{(GW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [GW-1:0] SAT_LO = {{(GW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  logic signed [SW-1:0] smp_a [NCH];
  logic [CFG_W-1:0]     cfg_a [NCH];

  for (genvar u = 0; u < NCH; u++) begin : g_unpack
    assign smp_a[u] = snap_samp[u*SW +: SW];
    assign cfg_a[u] = snap_cfg[u*CFG_W +: CFG_W];
  end

  mix_cfg_t cur;
  assign cur = mix_cfg_t'(cfg_a[step_ch]);

  logic signed [ACCW-1:0] own_t, a_t, b_t, c_t, sum;
  logic signed [GW-1:0]   widened, scaled, clamped;

  always_comb begin
    own_t = ACCW'(smp_a[step_ch]);
    a_t = '0;
    b_t = '0;
    c_t = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cur.src_a == 4'(i)) a_t = ACCW'(smp_a[i]);
      if (cur.src_b == 4'(i)) b_t = ACCW'(smp_a[i]);
      if (cur.src_c == 4'(i)) c_t = ACCW'(smp_a[i]);
    end
    sum = own_t;
    if (cur.mode != 2'b00) sum = sum + a_t;
    if (cur.mode[1])       sum = sum + b_t;
    if (cur.mode == 2'b11) sum = sum + c_t;
  end

  always_comb begin
    widened = GW'(sum);
    case (gain_code_e'(cur.gain))
      GAIN_UP6:  scaled = widened <<< 1;
      GAIN_DN12: scaled = widened >>> 2;
      GAIN_DN6:  scaled = widened >>> 1;
      default:   scaled = widened;
    endcase
    if (scaled > SAT_HI)      clamped = SAT_HI;
    else if (scaled < SAT_LO) clamped = SAT_LO;
    else                      clamped = scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= step_en;
      done      <= step_en && step_last;
      if (step_en) begin
        out_ch   <= step_ch;
        out_data <= clamped[SW-1:0];
      end
    end
  end

endmodule

// File: rtl/conf_mixer.sv
module conf_mixer
  import conf_mix_pkg::*;
#(
  parameter int NCH = 8,
  parameter int SW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [NCH*SW-1:0]    samp_in,
  input  logic [NCH*CFG_W-1:0] cfg_in,
  output logic                 out_valid,
  output logic [CHW-1:0]       out_ch,
  output logic [SW-1:0]        out_data,
  output logic                 done
);

  logic                 capture, step_en, step_last;
  logic [CHW-1:0]       step_ch;
  logic [NCH*SW-1:0]    samp_q;
  logic [NCH*CFG_W-1:0] cfg_q;

  conf_mix_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .capture(capture), .step_en(step_en),
    .step_ch(step_ch), .step_last(step_last)
  );

  conf_mix_snap #(.NCH(NCH), .SW(SW)) u_snap (
    .clk(clk), .rst(rst), .capture(capture),
    .samp_in(samp_in), .cfg_in(cfg_in),
    .samp_q(samp_q), .cfg_q(cfg_q)
  );

  conf_mix_core #(.NCH(NCH), .SW(SW)) u_core (
    .clk(clk), .rst(rst),
    .step_en(step_en), .step_ch(step_ch), .step_last(step_last),
    .snap_samp(samp_q), .snap_cfg(cfg_q),
    .out_valid(out_valid), .out_ch(out_ch),
    .out_data(out_data), .done(done)
  );

endmodule

// File: rtl/conf_mixer_chk.sv
module conf_mixer_chk #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           out_valid,
  input logic [CHW-1:0] out_ch,
  input logic           done
);

  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  assert_first_chan_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_ch == '0);

  assert_chan_step_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ch != LAST_CH) |=> (out_valid && out_ch == CHW'($past(out_ch) + 1'b1)));

  assert_done_with_last_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_valid && out_ch == LAST_CH));

  assert_last_has_done_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ch == LAST_CH) |-> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !out_valid));

endmodule

bind conf_mixer conf_mixer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ch(out_ch), .done(done)
);

// File: tb/conf_mixer_test.sv
module conf_mixer_test;

  localparam int NCH = 8;
  localparam int SW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NCH*SW-1:0] samp_in;
  logic [NCH*16-1:0] cfg_in;
  logic out_valid, done;
  logic [2:0] out_ch;
  logic [SW-1:0] out_data;

  logic signed [15:0] smp [NCH];
  logic [15:0]        cfg [NCH];
  logic signed [15:0] smp_s [NCH];
  logic [15:0]        cfg_s [NCH];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      samp_in[k*SW +: SW] = smp[k];
      cfg_in[k*16 +: 16]  = cfg[k];
    end
  end

  conf_mixer #(.NCH(NCH), .SW(SW)) uut (
    .clk(clk), .rst(rst), .start(start), .samp_in(samp_in), .cfg_in(cfg_in),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int g, input int m, input int a, input int b, input int c);
    return {2'(g), 2'(m), 4'(a), 4'(b), 4'(c)};
  endfunction

  function automatic int pick(input logic [3:0] idx);
    return (idx < NCH) ? int'(smp_s[idx]) : 0;
  endfunction

  function automatic int model(input int ch);
    int s, g, m;
    s = int'(smp_s[ch]);
    m = int'(cfg_s[ch][13:12]);
    if (m >= 1) s += pick(cfg_s[ch][11:8]);
    if (m >= 2) s += pick(cfg_s[ch][7:4]);
    if (m == 3) s += pick(cfg_s[ch][3:0]);
    case (cfg_s[ch][15:14])
      2'b01:   g = s * 2;
      2'b10:   g = s >>> 2;
      2'b11:   g = s >>> 1;
      default: g = s;
    endcase
    if (g > 32767)  g = 32767;
    if (g < -32768) g = -32768;
    return g;
  endfunction

  // Start on a falling edge; results for channel k are checked on the (k+2)-th falling edge after.
  task automatic run_frame(input string req, input bit disturb);
    for (int k = 0; k < NCH; k++) begin
      smp_s[k] = smp[k];
      cfg_s[k] = cfg[k];
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      for (int k = 0; k < NCH; k++) begin
        smp[k] = 16'sh7000;
        cfg[k] = mk(1, 3, k, k, k);
      end
      start = 1'b1;
    end
    for (int k = 0; k < NCH; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(out_valid === 1'b1, "R2 valid", int'(out_valid), 1);
      chk(out_ch == 3'(k), "R2 channel order", int'(out_ch), k);
      chk($signed(out_data) == 16'(model(k)), req, int'($signed(out_data)), model(k));
      chk(done == (k == NCH - 1), "R9 done timing", int'(done), int'(k == NCH - 1));
    end
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      chk(!out_valid && !done, "R9 idle after frame", int'(out_valid), 0);
    end
  endtask

  task automatic t_reset;
    chk(out_valid === 1'b0, "R1 valid", int'(out_valid), 0);
    chk(done === 1'b0, "R1 done", int'(done), 0);
    chk(out_data === 16'h0, "R1 data", int'(out_data), 0);
  endtask

  task automatic t_own_gain;
    // R3 mode 00 with each gain code (R5), positive and negative, odd values for rounding
    smp[0] = 16'sd1000;  cfg[0] = mk(0, 0, 1, 2, 3);
    smp[1] = -16'sd1000; cfg[1] = mk(1, 0, 0, 0, 0);
    smp[2] = 16'sd1003;  cfg[2] = mk(2, 0, 5, 5, 5);
    smp[3] = -16'sd1003; cfg[3] = mk(2, 0, 5, 5, 5);
    smp[4] = 16'sd777;   cfg[4] = mk(3, 0, 0, 1, 2);
    smp[5] = -16'sd777;  cfg[5] = mk(3, 0, 0, 1, 2);
    smp[6] = -16'sd1;    cfg[6] = mk(3, 0, 7, 7, 7);
    smp[7] = 16'sd0;     cfg[7] = mk(1, 0, 1, 1, 1);
    run_frame("R3 R5 own sample with gain", 1'b0);
  endtask

  task automatic t_modes;
    // R4 source counts, duplicates and self reference; R7 field positions
    for (int k = 0; k < NCH; k++) smp[k] = 16'(100 * (k + 1) * ((k % 2 == 0) ? 1 : -1));
    cfg[0] = mk(0, 1, 3, 5, 6);
    cfg[1] = mk(0, 2, 2, 4, 7);
    cfg[2] = mk(0, 3, 0, 1, 4);
    cfg[3] = mk(0, 3, 4, 5, 6);
    cfg[4] = mk(0, 2, 4, 4, 1);
    cfg[5] = mk(3, 3, 6, 6, 6);
    cfg[6] = mk(0, 1, 0, 7, 7);
    cfg[7] = mk(2, 3, 1, 2, 3);
    run_frame("R4 R7 source mixing", 1'b0);
  endtask

  task automatic t_saturate;
    // R6 clamping after gain at both rails
    smp[0] = 16'sd30000;  cfg[0] = mk(0, 3, 1, 2, 3);
    smp[1] = 16'sd30000;  cfg[1] = mk(1, 0, 0, 0, 0);
    smp[2] = 16'sd30000;  cfg[2] = mk(2, 3, 0, 1, 3);
    smp[3] = 16'sd30000;  cfg[3] = mk(3, 1, 0, 0, 0);
    smp[4] = -16'sd30000; cfg[4] = mk(0, 3, 5, 6, 7);
    smp[5] = -16'sd30000; cfg[5] = mk(1, 0, 0, 0, 0);
    smp[6] = -16'sd30000; cfg[6] = mk(2, 3, 4, 5, 7);
    smp[7] = -16'sd32768; cfg[7] = mk(0, 0, 0, 0, 0);
    run_frame("R6 saturation", 1'b0);
  endtask

  task automatic t_bad_index;
    // R7 indices of NCH and above add nothing
    for (int k = 0; k < NCH; k++) begin
      smp[k] = 16'(500 + k);
      cfg[k] = mk(0, 3, 8 + k, 15, (k % 2 == 0) ? 9 : k);
    end
    run_frame("R7 out-of-range index", 1'b0);
  endtask

  task automatic t_snapshot;
    // R8 inputs changed after start; R9 start during a frame ignored
    for (int k = 0; k < NCH; k++) begin
      smp[k] = 16'(-200 * k + 50);
      cfg[k] = mk(k % 4, 3 - (k % 4), (k + 1) % NCH, (k + 2) % NCH, (k + 3) % NCH);
    end
    run_frame("R8 snapshot isolation", 1'b1);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin
      smp[k] = '0;
      cfg[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_own_gain();
    t_modes();
    t_saturate();
    t_bad_index();
    t_snapshot();
    t_modes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule